// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM in which every access has the same two-cycle pipeline, so reads and writes can share one data bus with no idle cycles between them. Each active clock edge registers an address and a command. The data for that command uses the bus in the cycle that ends two edges later. For a read, the word is driven after the next edge. For a write, the word is captured at the second edge. The word is 36 bits, made of four 9-bit byte lanes. The depth is set by a parameter.

An active-low clock enable stretches the current cycle by freezing every register. Three chip enables select the device. A deselecting load starts no new access, but accesses already in the pipeline still finish. Each loaded address can be followed by advance cycles. These step an internal 2-bit beat counter through four beats, in linear order or interleaved order. The bidirectional bus is split into a write-data input, a read-data output and a drive flag. The drive flag also depends on an asynchronous active-low output enable.

Top module: `zbt_sram`

## Requirements
- R1: A read command registered at edge N makes its word appear on `rdata_o`, with `drive_o` high (when `oe_ni` is low), after edge N+1. A write command registered at edge N stores `wdata_i` at edge N+2. Reads and writes can be issued on consecutive edges in any mix, with no idle edge between them.
- R2: While `cke_ni` is high, every synchronous input is ignored and no register or memory word changes. `rdata_o` holds its value, and the pipeline resumes where it stopped.
- R3: A load selects the device only when `sel1_ni`=0, `sel2_i`=1 and `sel3_ni`=0. Any other combination counts as a deselect.
- R4: A load (`adv_i`=0) made while deselected starts no access and ends any burst in progress, so later advance cycles do nothing. Accesses already registered still complete.
- R5: An advance (`adv_i`=1) after a selecting load issues the next beat of the burst. The beat counter is 2 bits wide and wraps, so the fifth beat reuses the loaded address. Address bits above bit 1 stay fixed.
- R6: When `ilv_i`=1, the low two address bits of beat k are the loaded bits XOR k. When `ilv_i`=0, they are the loaded bits plus k, modulo 4.
- R7: `bw_ni[k]`=0 enables write lane k, which is data bits [9k+8:9k]. Lanes whose select is high keep their stored value.
- R8: `drive_o` is high only while `oe_ni` is low and the current data window belongs to a read. It is low in the window of a write, in the window of a deselect, and in the window of an idle cycle.
- R9: A read registered one edge after a write to the same address returns the newly merged word, even though that word reaches the array on the same edge.
- R10: Every beat of a burst repeats the read/write type and the lane mask of the load that started it.
- R11: After reset, `drive_o` and `rdata_o` are zero, no burst is active, and advance cycles start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| sel1_ni | input | 1 | Chip enable, active low |
| sel2_i | input | 1 | Chip enable, active high |
| sel3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | NL (4) | Lane write selects, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| ilv_i | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_i | input | AW (6) | Word address |
| wdata_i | input | NL*LW (36) | Write data |
| rdata_o | output | NL*LW (36) | Read data |
| drive_o | output | 1 | Bus drive enable |

## Verification
The assertions assume that reset is asserted from time zero and that `ilv_i` only changes while no burst is advancing. They also assume that an antecedent spanning two edges has `cke_ni` low on both edges. The properties state this in their antecedents instead of assuming it. The stimulus changes `ilv_i` only between bursts and toggles `oe_ni` only by itself. The bench first writes every word, so no read ever returns an uninitialised value. It drives all inputs two nanoseconds after the rising edge, which keeps them stable at every sampled edge.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  localparam int BEATS = 4;

  // Low address bits for one burst beat.
  function automatic logic [1:0] beat_ofs(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/zbt_sram_cmd.sv
module zbt_sram_cmd
  import zbt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          load_i,
  input  logic          wr_i,
  input  logic [NL-1:0] ben_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ilv_i,
  output logic          op_vld_o,
  output logic          op_wr_o,
  output logic [NL-1:0] op_ben_o,
  output logic [AW-1:0] op_addr_o
);
  logic          act_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nx;
  logic          wr_q;
  logic [NL-1:0] ben_q;

  assign cnt_nx = cnt_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      wr_q      <= 1'b0;
      ben_q     <= '0;
      op_vld_o  <= 1'b0;
      op_wr_o   <= 1'b0;
      op_ben_o  <= '0;
      op_addr_o <= '0;
    end else if (en_i) begin
      if (load_i) begin
        act_q    <= sel_i;
        op_vld_o <= sel_i;
        if (sel_i) begin
          base_q    <= addr_i;
          cnt_q     <= '0;
          wr_q      <= wr_i;
          ben_q     <= ben_i;
          op_wr_o   <= wr_i;
          op_ben_o  <= ben_i;
          op_addr_o <= addr_i;
        end
      end else begin
        op_vld_o <= act_q;
        if (act_q) begin
          cnt_q     <= cnt_nx;
          op_wr_o   <= wr_q;
          op_ben_o  <= ben_q;
          op_addr_o <= {base_q[AW-1:2], beat_ofs(base_q[1:0], cnt_nx, ilv_i)};
        end
      end
    end
  end
endmodule

// File: rtl/zbt_sram_store.sv
module zbt_sram_store #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          op_vld_i,
  input  logic          op_wr_i,
  input  logic [NL-1:0] op_ben_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_vld_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic          s2_vld_q, s2_wr_q;
  logic [NL-1:0] s2_ben_q;
  logic [AW-1:0] s2_addr_q;
  logic [DW-1:0] old_w, new_w, rd_w;
  logic          commit, hit;

  assign old_w = mem_q[s2_addr_q];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign new_w[l*LW +: LW] = s2_ben_q[l] ? wdata_i[l*LW +: LW] : old_w[l*LW +: LW];
  end

  assign commit = en_i & s2_vld_q & s2_wr_q;
  // write landing this edge is forwarded to a read issued right behind it
  assign hit    = commit && (s2_addr_q == op_addr_i);
  assign rd_w   = hit ? new_w : mem_q[op_addr_i];

  always_ff @(posedge clk_i) begin
    if (commit) mem_q[s2_addr_q] <= new_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q  <= 1'b0;
      s2_wr_q   <= 1'b0;
      s2_ben_q  <= '0;
      s2_addr_q <= '0;
      rd_vld_o  <= 1'b0;
      rdata_o   <= '0;
    end else if (en_i) begin
      s2_vld_q  <= op_vld_i;
      s2_wr_q   <= op_wr_i;
      s2_ben_q  <= op_ben_i;
      s2_addr_q <= op_addr_i;
      rd_vld_o  <= op_vld_i & ~op_wr_i;
      if (op_vld_i && !op_wr_i) rdata_o <= rd_w;
    end
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          sel1_ni,
  input  logic          sel2_i,
  input  logic          sel3_ni,
  input  logic          adv_i,
  input  logic          we_ni,
  input  logic [NL-1:0] bw_ni,
  input  logic          oe_ni,
  input  logic          ilv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  logic          en, sel;
  logic          op_vld, op_wr, rd_vld;
  logic [NL-1:0] op_ben;
  logic [AW-1:0] op_addr;

  assign en  = ~cke_ni;
  assign sel = ~sel1_ni & sel2_i & ~sel3_ni;

  zbt_sram_cmd #(.AW(AW), .NL(NL)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .sel_i     (sel),
    .load_i    (~adv_i),
    .wr_i      (~we_ni),
    .ben_i     (~bw_ni),
    .addr_i    (addr_i),
    .ilv_i     (ilv_i),
    .op_vld_o  (op_vld),
    .op_wr_o   (op_wr),
    .op_ben_o  (op_ben),
    .op_addr_o (op_addr)
  );

  zbt_sram_store #(.AW(AW), .NL(NL), .LW(LW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .op_vld_i  (op_vld),
    .op_wr_i   (op_wr),
    .op_ben_i  (op_ben),
    .op_addr_i (op_addr),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .rd_vld_o  (rd_vld)
  );

  assign drive_o = rd_vld & ~oe_ni;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cke_ni,
  input logic          sel1_ni,
  input logic          sel2_i,
  input logic          sel3_ni,
  input logic          adv_i,
  input logic          we_ni,
  input logic [NL-1:0] bw_ni,
  input logic          oe_ni,
  input logic          ilv_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          drive_o
);
  logic picked;
  assign picked = ~sel1_ni & sel2_i & ~sel3_ni;

  p_drive_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> !oe_ni);

  p_freeze_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(rdata_o));

  p_desel_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && !picked) ##1 !cke_ni |=> !drive_o);

  p_write_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && picked && !we_ni) ##1 !cke_ni |=> !drive_o);

  p_read_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && picked && we_ni) ##1 !cke_ni |=> (oe_ni || drive_o));
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .NL(NL), .LW(LW)) u_chk (.*);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_ni = 1'b0;
  logic          sel1_ni = 1'b1, sel2_i = 1'b0, sel3_ni = 1'b1;
  logic          adv_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b0, ilv_i = 1'b0;
  logic [NL-1:0] bw_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R11";
  bit    done = 0;

  always #4 clk_i = ~clk_i;

  zbt_sram #(.AW(AW), .NL(NL), .LW(LW)) u_zbt_sram (.*);

  // behavioural reference
  logic [DW-1:0] m_mem [DEPTH];
  bit            m1_v, m1_w, m2_v, m2_w, b_on, b_w, e_rd;
  logic [NL-1:0] m1_b, m2_b, b_b;
  int            m1_a, m2_a, b_base, b_cnt, lo;
  logic [DW-1:0] e_dat;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_v = 0; m2_v = 0; b_on = 0; e_rd = 0; e_dat = '0;
    end else if (!cke_ni) begin
      if (m2_v && m2_w)
        for (int l = 0; l < NL; l++)
          if (m2_b[l]) m_mem[m2_a][l*LW +: LW] = wdata_i[l*LW +: LW];
      e_rd = m1_v && !m1_w;
      if (e_rd) e_dat = m_mem[m1_a];
      m2_v = m1_v; m2_w = m1_w; m2_b = m1_b; m2_a = m1_a;
      if (!adv_i) begin
        if (!sel1_ni && sel2_i && !sel3_ni) begin
          b_on = 1; b_base = int'(addr_i); b_cnt = 0; b_w = !we_ni; b_b = ~bw_ni;
          m1_v = 1; m1_w = b_w; m1_b = b_b; m1_a = b_base;
        end else begin
          b_on = 0; m1_v = 0;
        end
      end else if (b_on) begin
        b_cnt = (b_cnt + 1) % 4;
        lo = ilv_i ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
        m1_v = 1; m1_w = b_w; m1_b = b_b; m1_a = (b_base / 4) * 4 + lo;
      end else begin
        m1_v = 0;
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(drive_o === (e_rd && !oe_ni), "drive", DW'(drive_o), DW'(e_rd && !oe_ni));
      if (e_rd && !oe_ni) check(rdata_o === e_dat, "rdata", rdata_o, e_dat);
    end
  end

  task automatic drv(input bit ck_n, input bit ld, input bit s1n, input bit s2, input bit s3n,
                     input bit wen, input logic [NL-1:0] bwn, input int a, input bit oen = 0);
    @(posedge clk_i);
    #2;
    cke_ni = ck_n; adv_i = !ld; sel1_ni = s1n; sel2_i = s2; sel3_ni = s3n;
    we_ni = wen; bw_ni = bwn; addr_i = AW'(a); oe_ni = oen;
    wdata_i = DW'({$urandom(), $urandom()});
  endtask

  task automatic wr(input int a, input logic [NL-1:0] bwn = '0); drv(0, 1, 0, 1, 0, 0, bwn, a); endtask
  task automatic rd(input int a, input bit oen = 0); drv(0, 1, 0, 1, 0, 1, '1, a, oen); endtask
  task automatic adv(input bit oen = 0); drv(0, 0, 0, 1, 0, 1, '1, 0, oen); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) drv(0, 1, 1, 0, 1, 1, '1, 0); endtask

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R11";
    check(drive_o === 1'b0 && rdata_o === '0, "reset outputs", rdata_o, '0);
    for (int i = 0; i < 4; i++) adv();
    // fill memory with 4-beat linear write bursts
    cur_req = "R5";
    for (int b = 0; b < DEPTH / 4; b++) begin
      wr(b * 4);
      for (int k = 0; k < 3; k++) adv();
    end
    idle(3);
    // linear vs interleaved order, wrap past beat four
    cur_req = "R6";
    ilv_i = 0; rd(6); for (int k = 0; k < 5; k++) adv(); idle(3);
    ilv_i = 1; rd(9); for (int k = 0; k < 5; k++) adv(); idle(3);
    ilv_i = 1; rd(15); for (int k = 0; k < 3; k++) adv(); idle(3);
    ilv_i = 0;
    // alternating traffic, no dead cycles
    cur_req = "R1";
    for (int i = 0; i < 12; i++) begin wr(i * 5 % DEPTH); rd(i * 3 % DEPTH); end
    rd(20); wr(21); rd(22); wr(23); rd(21); rd(23);
    idle(3);
    // read right behind write to same word
    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin wr(i + 30, 4'(i * 5)); rd(i + 30); end
    wr(40); wr(40, 4'b1010); rd(40); rd(40);
    idle(3);
    // lane masks
    cur_req = "R7";
    for (int m = 0; m < 16; m++) begin wr(50, 4'(m)); idle(1); rd(50); end
    idle(3);
    // burst repeats loader type and mask
    cur_req = "R10";
    wr(44, 4'b0101); for (int k = 0; k < 3; k++) adv();
    rd(44); for (int k = 0; k < 3; k++) adv();
    wr(17, 4'b1100); adv(); rd(12); adv(); adv(); adv();
    idle(3);
    // chip enable decode
    cur_req = "R3";
    drv(0, 1, 1, 1, 0, 1, '1, 3); adv();
    drv(0, 1, 0, 0, 0, 1, '1, 3); adv();
    drv(0, 1, 0, 1, 1, 1, '1, 3); adv();
    drv(0, 1, 0, 1, 0, 0, '0, 3); drv(0, 1, 1, 1, 0, 0, '0, 4);
    rd(3); rd(4); idle(3);
    // deselect ends burst, pending ops finish
    cur_req = "R4";
    rd(24); adv(); drv(0, 1, 0, 0, 0, 1, '1, 0); adv(); adv(); adv();
    wr(28); adv(); drv(0, 1, 1, 1, 1, 0, '0, 0); adv(); adv(); rd(28); adv(); adv(); adv();
    idle(3);
    // clock enable freezes everything
    cur_req = "R2";
    rd(36); wr(37);
    for (int i = 0; i < 4; i++) drv(1, 1, 0, 1, 0, 0, '0, 37);
    rd(37); adv();
    for (int i = 0; i < 3; i++) drv(1, i % 2, 0, 1, 0, i % 2, 4'(i), i);
    adv(); adv(); idle(2);
    for (int i = 0; i < 3; i++) drv(1, 0, 0, 1, 0, 1, '1, 0);
    idle(3);
    // output enable and drive rules
    cur_req = "R8";
    rd(10); rd(11, 1); rd(12); wr(13); rd(13, 1); rd(13); idle(1); rd(14);
    adv(1); adv(); adv(1);
    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule